// File: doc/BRIEF.md
# Fixed-Upper Program Bank Mapper

This block sits on the cartridge side of an 8-bit CPU bus with a 16-bit address space. It turns the CPU address into the high address bits of a banked program ROM. The ROM is split into 16 KB banks. The lower half of the cartridge area, $8000-$BFFF, shows whichever bank the bank register holds. The upper half, $C000-$FFFF, is tied to the last bank in the ROM, so reset vectors and fixed code are always there. A CPU write anywhere in $8000-$FFFF loads the bank register from the data bus.

A parameter sets the register width. With 3 bits the block addresses 8 banks (a 128 KB ROM). With 4 bits it addresses 16 banks (a 256 KB ROM). The ROM address and chip enable are combinational from the bus and the register, so a fetch sees its bank in the same cycle. A register load takes effect at the next rising clock edge. The bus has no handshake: every strobe is accepted in the cycle it appears, and no back-pressure is possible.

Top module: `prg_bank_map`

## Requirements
- R1: When `cpu_wr`=1 and `cpu_addr[15]`=1 at a rising clock edge, the bank register takes `cpu_data[BANK_W-1:0]` and ignores the higher data bits.
- R2: A write with `cpu_addr[15]`=0 leaves the bank register unchanged.
- R3: An active-low `rst_n` clears the bank register to zero.
- R4: When `cpu_addr[14]`=0, `rom_addr` equals {bank register, `cpu_addr[13:0]`}.
- R5: When `cpu_addr[14]`=1, the bank field of `rom_addr` is all ones, whatever the register holds, and the low 14 bits are `cpu_addr[13:0]`.
- R6: `rom_ce` is 1 exactly when `cpu_addr[15]`=1 and `cpu_wr`=0.
- R7: With `BANK_W`=3, `rom_addr` is 17 bits wide and the fixed bank is 7. With `BANK_W`=4, it is 18 bits wide and the fixed bank is 15.
- R8: In the cycle that holds a register load, `rom_addr` still uses the previous register value. The new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, active high |
| rom_addr | output | BANK_W+14 | Program ROM byte address |
| rom_ce | output | 1 | Program ROM chip enable for reads in $8000-$FFFF |

## Verification
A register load and a lower-window address lookup can happen in the same cycle, because the write itself drives an address that the mapper decodes. The bench places loads at $8000 and $A000 while the register holds a known bank, then reads `rom_addr` before the edge and expects the old bank. After the edge it expects the newly written bank. A load at $FFFF checks that the upper window stays on the last bank while the register changes under it.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int OFFS_W = 14;
  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;

  typedef enum logic {
    WIN_SWITCH = 1'b0,
    WIN_FIXED  = 1'b1
  } win_e;

  function automatic win_e pick_window(input logic addr14);
    return addr14 ? WIN_FIXED : WIN_SWITCH;
  endfunction

endpackage

// File: rtl/prg_bank_reg.sv
module prg_bank_reg
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CPU_DW-1:0] load_data,
  output logic [BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_next;

  always_comb begin
    bank_next = load_en ? load_data[BANK_W-1:0] : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_next;
  end

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> bank_q == $past(load_data[BANK_W-1:0])); // R1
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(bank_q)); // R2

endmodule

// File: rtl/prg_win_decode.sv
module prg_win_decode
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [BANK_W-1:0] bank_q,
  output logic [BANK_W-1:0] bank_sel,
  output logic              load_en,
  output logic              rom_ce
);

  localparam logic [BANK_W-1:0] LAST_BANK = {BANK_W{1'b1}};

  win_e win;
  logic in_cart;

  always_comb begin
    in_cart = cpu_addr[CPU_AW-1];
    win     = pick_window(cpu_addr[OFFS_W]);
    load_en = cpu_wr & in_cart;
    rom_ce  = in_cart & ~cpu_wr;
  end

  // Upper window: OR the register with a mask of all ones.
  genvar b;
  generate
    for (b = 0; b < BANK_W; b++) begin : g_bank_bit
      assign bank_sel[b] = bank_q[b] | (win == WIN_FIXED);
    end
  endgenerate

  AST_UPPER_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[OFFS_W] |-> bank_sel == LAST_BANK); // R5
  AST_LOWER_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[OFFS_W] |-> bank_sel == bank_q); // R4
  AST_CE_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce |-> (cpu_addr[CPU_AW-1] && !cpu_wr)); // R6
  AST_CE_NO_WRITE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_ce && load_en)); // R6

endmodule

// File: rtl/prg_bank_map.sv
module prg_bank_map
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 4,
  localparam int ROM_W = BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  output logic [ROM_W-1:0]  rom_addr,
  output logic              rom_ce
);

  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_sel;
  logic              load_en;

  generate
    if (BANK_W != 3 && BANK_W != 4) begin : g_bad_width
      initial $error("prg_bank_map: BANK_W must be 3 or 4"); // R7
    end
  endgenerate

  prg_win_decode #(.BANK_W(BANK_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .bank_q   (bank_q),
    .bank_sel (bank_sel),
    .load_en  (load_en),
    .rom_ce   (rom_ce)
  );

  prg_bank_reg #(.BANK_W(BANK_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (cpu_data),
    .bank_q    (bank_q)
  );

  assign rom_addr = {bank_sel, cpu_addr[OFFS_W-1:0]};

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> rom_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]); // R4
  AST_LOAD_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !cpu_addr[OFFS_W]) |-> rom_addr[ROM_W-1:OFFS_W] == bank_q); // R8

endmodule

// File: tb/test_prg_bank_map.sv
module test_prg_bank_map;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [17:0] rom_addr;
  logic        rom_ce;
  logic [16:0] rom_addr_n;
  logic        rom_ce_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  prg_bank_map #(.BANK_W(4)) i_prg_bank_map (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_ce(rom_ce)
  );

  prg_bank_map #(.BANK_W(3)) i_prg_bank_map_narrow (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .rom_addr(rom_addr_n), .rom_ce(rom_ce_n)
  );

  // {wr, addr, data, expected rom_addr (before edge), expected ce}
  localparam int NV = 15;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 16'h8000, 8'h00, 18'h00000, 1'b1},  // R4 reset bank
    {1'b1, 16'h8000, 8'h05, 18'h00000, 1'b0},  // R8 old bank during load
    {1'b0, 16'h8123, 8'h00, 18'h14123, 1'b1},  // R1 R4
    {1'b0, 16'hC456, 8'h00, 18'h3C456, 1'b1},  // R5
    {1'b1, 16'h6000, 8'h0A, 18'h3E000, 1'b0},  // R2 low write
    {1'b0, 16'h9000, 8'h00, 18'h15000, 1'b1},  // R2 still bank 5
    {1'b1, 16'hFFFF, 8'hF3, 18'h3FFFF, 1'b0},  // R1 R5 upper load
    {1'b0, 16'hBFFF, 8'h00, 18'h0FFFF, 1'b1},  // R1 high data bits dropped
    {1'b0, 16'h4000, 8'h00, 18'h3C000, 1'b0},  // R6 below cartridge
    {1'b0, 16'h0010, 8'h00, 18'h0C010, 1'b0},  // R6
    {1'b1, 16'hA000, 8'h0F, 18'h0E000, 1'b0},  // R8
    {1'b0, 16'h8000, 8'h00, 18'h3C000, 1'b1},  // R4 bank 15 in lower
    {1'b1, 16'h8000, 8'h00, 18'h3C000, 1'b0},  // R8
    {1'b0, 16'hC000, 8'h00, 18'h3C000, 1'b1},  // R5 fixed with reg 0
    {1'b0, 16'h8001, 8'h00, 18'h00001, 1'b1}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = wr;
    cpu_addr = a;
    cpu_data = d;
    #5;
  endtask

  initial begin
    #100000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(1'b0, 16'h8abc, 8'h00);
    check("R3", 32'(rom_addr), 32'h00abc);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][43], VEC[i][42:27], VEC[i][26:19]);
      check("R4/R5/R8 rom_addr", 32'(rom_addr), 32'(VEC[i][18:1]));
      check("R6 rom_ce", 32'(rom_ce), 32'(VEC[i][0]));
    end

    // R3: reset clears a loaded bank
    drive(1'b1, 16'h8000, 8'h07);
    drive(1'b0, 16'h8000, 8'h00);
    check("R1", 32'(rom_addr), 32'h1C000);
    rst_n = 1'b0;
    #2;
    check("R3", 32'(rom_addr), 32'h00000);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: narrow build, 8 banks, 17-bit address
    drive(1'b1, 16'hC000, 8'hFF);
    drive(1'b0, 16'h8000, 8'h00);
    check("R7 narrow load", 32'(rom_addr_n), 32'h1C000);
    drive(1'b0, 16'hC005, 8'h00);
    check("R7 narrow fixed", 32'(rom_addr_n), 32'h1C005);
    drive(1'b1, 16'h8000, 8'h02);
    check("R8 narrow old", 32'(rom_addr_n), 32'h1C000);
    drive(1'b0, 16'h8010, 8'h00);
    check("R7 narrow bank2", 32'(rom_addr_n), 32'h08010);
    drive(1'b0, 16'hFFFF, 8'h00);
    check("R7 narrow top", 32'(rom_addr_n), 32'h1FFFF);
    check("R6 narrow ce", 32'(rom_ce_n), 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule